// File: doc/BRIEF.md
# Clock Manager Boot-Mode Control Register

This block is the top-level control word of a clock manager. It is one 32-bit register on a simple register bus. It has three defined fields. The first is a boot-mode flag. While that flag is set, every downstream clock is bypassed and every external counter and divider is forced to divide by one. The other two fields are a software enable and a software choice for the boot clock source. When the enable is set, the software choice drives the boot clock mux select. When it is clear, a fuse-derived select drives it instead.

The fields react differently to the two reset inputs. A cold reset restores every field. A warm reset never touches the source-control fields. On a warm reset, the boot-mode flag is set again only when a policy input asks for it. Only privileged accesses may reach the register. A non-privileged access is refused and flagged on an error output.

Both outputs that go to the clock tree are registered. Downstream logic therefore sees a clean, glitch-free change one cycle after the write or input change that causes it. The mux, dividers and PLLs themselves are outside this block.

Top module: `clkctl_boot_reg`

## Requirements
- R1: The register sits at address `REG_OFFSET` (default 0). Bit 0 holds the boot-mode flag, bit 8 the software source enable and bit 9 the software source choice. All other bits read as 0, and writing them has no effect.
- R2: While `cold_rst` is high, the fields become boot=1, enable=0, choice=0. On the edge that samples it, `boot_mode` becomes 1 and `boot_clk_sel` becomes 0.
- R3: A warm reset leaves bits 8 and 9 unchanged.
- R4: A warm reset sets bit 0 when `warm_boot_policy` is 1. When `warm_boot_policy` is 0, bit 0 keeps its value.
- R5: When cold and warm reset are high together, the cold reset behaviour applies.
- R6: An access (read or write) to the register with `bus_priv`=0 leaves the fields unchanged. On the next cycle it raises `bus_err` for one cycle and drives `bus_rdata` to 0.
- R7: `boot_clk_sel` equals bit 9 when bit 8 is 1, and equals `fuse_sel` when bit 8 is 0. Value 1 selects the internal high-speed oscillator divided by 2. Value 0 selects the external oscillator.
- R8: `boot_mode` follows bit 0. Writing 1 to bit 0 enters boot mode and writing 0 leaves it.
- R9: A write sampled at edge k changes the fields at edge k. `boot_mode` and `boot_clk_sel` change at edge k+1. `bus_rdata` and `bus_err` are registered and show the result of an access sampled at edge k.
- R10: Accesses are ignored while either reset is high. An access to any other address changes nothing, returns 0 and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| warm_boot_policy | input | 1 | 1: warm reset re-enters boot mode |
| fuse_sel | input | 1 | Fuse-derived boot clock select |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Full-word write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | 1 for a privileged access |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Registered access error pulse |
| boot_clk_sel | output | 1 | Resolved boot clock mux select |
| boot_mode | output | 1 | Forces bypass and divide-by-one |

## Verification
A corrupted field shows up at the ports in one of two ways. It appears in the read data of the next privileged read. It also appears in `boot_mode` or `boot_clk_sel` exactly one edge after it arises. Because of this, the bench compares all four outputs against a cycle-exact model after every edge. A wrong reset response is the main risk here, for example a warm reset clearing the source fields or ignoring the policy input. Such a fault surfaces within two cycles through the next readback and the registered select.

// File: rtl/clkctl_boot_pkg.sv
package clkctl_boot_pkg;

   localparam int unsigned CK_BOOT_POS = 0;
   localparam int unsigned CK_EN_POS   = 8;
   localparam int unsigned CK_SEL_POS  = 9;

   typedef struct packed {
      logic sw_sel;
      logic sw_en;
      logic boot;
   } ck_fields_t;

   localparam ck_fields_t CK_COLD_FIELDS = '{sw_sel: 1'b0, sw_en: 1'b0, boot: 1'b1};

endpackage

// File: rtl/clkctl_bus_dec.sv
module clkctl_bus_dec
   import clkctl_boot_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_OFFSET = 0,
   parameter int unsigned BOOT_POS   = CK_BOOT_POS,
   parameter int unsigned EN_POS     = CK_EN_POS,
   parameter int unsigned SEL_POS    = CK_SEL_POS
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              warm_rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_priv,
   input  ck_fields_t        fields,
   output logic              wr_ok,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

   logic hit;
   logic in_rst;
   logic any_acc;
   logic [DATA_W-1:0] rd_word;

   assign hit     = (bus_addr == HIT_ADDR);
   assign in_rst  = cold_rst | warm_rst;
   assign any_acc = (bus_wr | bus_rd) & hit & ~in_rst;
   assign wr_ok   = bus_wr & hit & bus_priv & ~in_rst;

   always_comb begin
      rd_word           = '0;
      rd_word[BOOT_POS] = fields.boot;
      rd_word[EN_POS]   = fields.sw_en;
      rd_word[SEL_POS]  = fields.sw_sel;
   end

   always_ff @(posedge clk) begin
      if (in_rst) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err   <= any_acc & ~bus_priv;
         bus_rdata <= (bus_rd & hit & bus_priv) ? rd_word : '0;
      end
   end

   // R6: a refused access never returns data
   a_r6_err_zero_data: assert property (@(posedge clk) disable iff (cold_rst)
      bus_err |-> (bus_rdata == '0));

   // R10: a miss never raises an error
   a_r10_miss_no_err: assert property (@(posedge clk) disable iff (cold_rst)
      ((bus_wr | bus_rd) & ~hit) |=> !bus_err);

endmodule

// File: rtl/clkctl_ctl_fields.sv
module clkctl_ctl_fields
   import clkctl_boot_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned BOOT_POS = CK_BOOT_POS,
   parameter int unsigned EN_POS   = CK_EN_POS,
   parameter int unsigned SEL_POS  = CK_SEL_POS
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              warm_rst,
   input  logic              warm_boot_policy,
   input  logic              wr_ok,
   input  logic [DATA_W-1:0] wr_word,
   output ck_fields_t        fields
);

   localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << BOOT_POS) | (DATA_W'(1) << EN_POS) | (DATA_W'(1) << SEL_POS);

   logic [DATA_W-1:0] cur_word;

   always_comb begin
      cur_word           = '0;
      cur_word[BOOT_POS] = fields.boot;
      cur_word[EN_POS]   = fields.sw_en;
      cur_word[SEL_POS]  = fields.sw_sel;
   end

   always_ff @(posedge clk) begin
      if (cold_rst) begin
         fields <= CK_COLD_FIELDS;
      end else if (warm_rst) begin
         if (warm_boot_policy) fields.boot <= 1'b1;
      end else if (wr_ok) begin
         fields.boot   <= wr_word[BOOT_POS];
         fields.sw_en  <= wr_word[EN_POS];
         fields.sw_sel <= wr_word[SEL_POS];
      end
   end

   // R2: fields hold their cold values right after a cold reset
   a_r2_cold_fields: assert property (@(posedge clk)
      (!cold_rst && $past(cold_rst)) |-> (fields == CK_COLD_FIELDS));

   // R3: warm reset keeps the source-control fields
   a_r3_warm_keeps_src: assert property (@(posedge clk) disable iff (cold_rst)
      warm_rst |=> ($stable(fields.sw_en) && $stable(fields.sw_sel)));

   // R4: warm reset with policy 0 keeps the boot flag
   a_r4_warm_policy_off: assert property (@(posedge clk) disable iff (cold_rst)
      (warm_rst && !warm_boot_policy) |=> $stable(fields.boot));

   // R1: reserved bits of a write have no effect
   a_r1_rsv_ignored: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      (wr_ok && ((wr_word & FIELD_MASK) == cur_word) && ((wr_word & ~FIELD_MASK) != '0))
      |=> $stable(fields));

endmodule

// File: rtl/clkctl_boot_out.sv
module clkctl_boot_out
   import clkctl_boot_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       cold_rst,
   input  ck_fields_t fields,
   input  logic       fuse_sel,
   output logic       boot_mode,
   output logic       boot_clk_sel
);

   logic sel_res;

   assign sel_res = fields.sw_en ? fields.sw_sel : fuse_sel;

   generate
      if (OUT_REG) begin : g_reg
         logic boot_q;
         logic sel_q;

         always_ff @(posedge clk) begin
            if (cold_rst) begin
               boot_q <= 1'b1;
               sel_q  <= 1'b0;
            end else begin
               boot_q <= fields.boot;
               sel_q  <= sel_res;
            end
         end

         assign boot_mode    = boot_q;
         assign boot_clk_sel = sel_q;

         // R7: registered select follows the resolved source one cycle later
         a_r7_sel_resolve: assert property (@(posedge clk) disable iff (cold_rst)
            !$past(cold_rst) |->
               (boot_clk_sel == ($past(fields.sw_en) ? $past(fields.sw_sel) : $past(fuse_sel))));

         // R8: boot_mode follows the flag one cycle later
         a_r8_boot_follow: assert property (@(posedge clk) disable iff (cold_rst)
            !$past(cold_rst) |-> (boot_mode == $past(fields.boot)));
      end else begin : g_comb
         assign boot_mode    = fields.boot;
         assign boot_clk_sel = sel_res;
         logic unused_ok;
         assign unused_ok = clk ^ cold_rst;
      end
   endgenerate

endmodule

// File: rtl/clkctl_boot_reg.sv
module clkctl_boot_reg
   import clkctl_boot_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_OFFSET = 0,
   parameter int unsigned BOOT_POS   = CK_BOOT_POS,
   parameter int unsigned EN_POS     = CK_EN_POS,
   parameter int unsigned SEL_POS    = CK_SEL_POS,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              warm_rst,
   input  logic              warm_boot_policy,
   input  logic              fuse_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              boot_clk_sel,
   output logic              boot_mode
);

   generate
      if (BOOT_POS >= DATA_W || EN_POS >= DATA_W || SEL_POS >= DATA_W) begin : g_chk_pos
         $error("clkctl_boot_reg: field position outside the data word");
      end
      if (BOOT_POS == EN_POS || BOOT_POS == SEL_POS || EN_POS == SEL_POS) begin : g_chk_dup
         $error("clkctl_boot_reg: field positions overlap");
      end
      if (ADDR_W < 32 && REG_OFFSET >= (64'd1 << ADDR_W)) begin : g_chk_addr
         $error("clkctl_boot_reg: REG_OFFSET does not fit in ADDR_W");
      end
   endgenerate

   ck_fields_t fields;
   logic       wr_ok;

   clkctl_bus_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET),
      .BOOT_POS(BOOT_POS), .EN_POS(EN_POS), .SEL_POS(SEL_POS)
   ) u_dec (
      .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
      .fields(fields), .wr_ok(wr_ok), .bus_rdata(bus_rdata), .bus_err(bus_err)
   );

   clkctl_ctl_fields #(
      .DATA_W(DATA_W), .BOOT_POS(BOOT_POS), .EN_POS(EN_POS), .SEL_POS(SEL_POS)
   ) u_fields (
      .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
      .warm_boot_policy(warm_boot_policy), .wr_ok(wr_ok), .wr_word(bus_wdata),
      .fields(fields)
   );

   clkctl_boot_out #(.OUT_REG(OUT_REG)) u_out (
      .clk(clk), .cold_rst(cold_rst), .fields(fields), .fuse_sel(fuse_sel),
      .boot_mode(boot_mode), .boot_clk_sel(boot_clk_sel)
   );

   // R6: a refused write leaves the fields alone
   a_r6_nonpriv_no_change: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
      (bus_wr && !bus_priv) |=> $stable(fields));

   // R5: cold reset wins over a simultaneous warm reset
   a_r5_cold_wins: assert property (@(posedge clk)
      (cold_rst && warm_rst && !warm_boot_policy) |=> (fields.boot && !fields.sw_en));

endmodule

// File: tb/clkctl_boot_reg_tb.sv
module clkctl_boot_reg_tb;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              cold_rst = 1'b1, warm_rst = 1'b0, warm_boot_policy = 1'b0, fuse_sel = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_err, boot_clk_sel, boot_mode;

   clkctl_boot_reg u_dut (
      .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
      .warm_boot_policy(warm_boot_policy), .fuse_sel(fuse_sel),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .boot_clk_sel(boot_clk_sel), .boot_mode(boot_mode)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   string dtag = "";

   // bench model of the fields
   logic m_boot = 1'b1, m_en = 1'b0, m_sel = 1'b0;

   function automatic logic [DATA_W-1:0] exp_word(logic b, logic e, logic s);
      logic [DATA_W-1:0] w;
      w = '0; w[0] = b; w[8] = e; w[9] = s;
      return w;
   endfunction

   task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string what);
      string t;
      t = (dtag != "") ? dtag : tag;
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
      end
   endtask

   task automatic cyc(logic c, logic w, logic pol, logic fu, logic [ADDR_W-1:0] a,
                      logic wr, logic rd, logic [DATA_W-1:0] wd, logic pr);
      logic [DATA_W-1:0] e_rd;
      logic e_err, e_boot, e_sel, hit, rst;
      cold_rst = c; warm_rst = w; warm_boot_policy = pol; fuse_sel = fu;
      bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; bus_priv = pr;
      @(posedge clk);
      hit = (a == '0); rst = c | w;
      e_err  = !rst && hit && (wr || rd) && !pr;
      e_rd   = (!rst && hit && rd && pr) ? exp_word(m_boot, m_en, m_sel) : '0;
      e_boot = c ? 1'b1 : m_boot;
      e_sel  = c ? 1'b0 : (m_en ? m_sel : fu);
      if (c) begin
         m_boot = 1'b1; m_en = 1'b0; m_sel = 1'b0;
      end else if (w) begin
         if (pol) m_boot = 1'b1;
      end else if (wr && hit && pr) begin
         m_boot = wd[0]; m_en = wd[8]; m_sel = wd[9];
      end
      @(negedge clk);
      chk(hit ? "R1" : "R10", bus_rdata, e_rd, "rdata");
      chk("R6", {31'b0, bus_err}, {31'b0, e_err}, "err");
      chk("R8", {31'b0, boot_mode}, {31'b0, e_boot}, "boot_mode");
      chk("R7", {31'b0, boot_clk_sel}, {31'b0, e_sel}, "boot_clk_sel");
   endtask

   task automatic idle(logic fu);
      cyc(0, 0, 0, fu, '0, 0, 0, '0, 1);
   endtask

   task automatic wr_reg(logic [DATA_W-1:0] d, logic pr);
      cyc(0, 0, 0, fuse_sel, '0, 1, 0, d, pr);
   endtask

   task automatic rd_reg(logic pr);
      cyc(0, 0, 0, fuse_sel, '0, 0, 1, '0, pr);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      // R2: cold reset state
      dtag = "R2";
      cyc(1, 0, 0, 1, '0, 0, 0, '0, 1);
      cyc(1, 0, 0, 1, '0, 0, 0, '0, 1);
      idle(1);
      rd_reg(1);
      chk("R2", bus_rdata, 32'h1, "cold readback");
      // R1: reserved bits ignored, fields written
      dtag = "R1";
      wr_reg(32'hFFFF_FFFE, 1);
      rd_reg(1);
      chk("R1", bus_rdata, 32'h300, "reserved ignored");
      // R9: output timing after a write
      dtag = "R9";
      wr_reg(32'h0000_0001, 1);
      chk("R9", {31'b0, boot_mode}, 32'h0, "boot_mode before k+1");
      idle(0);
      chk("R9", {31'b0, boot_mode}, 32'h1, "boot_mode at k+1");
      // R8: leave boot mode
      dtag = "R8";
      wr_reg(32'h0000_0300, 1);
      idle(0);
      chk("R8", {31'b0, boot_mode}, 32'h0, "boot left");
      // R3 / R4: warm reset, policy 0 keeps everything
      dtag = "R4";
      cyc(0, 1, 0, 0, '0, 1, 0, 32'h0, 1);
      rd_reg(1);
      chk("R3", bus_rdata, 32'h300, "warm policy 0 readback");
      // R4: warm with policy 1 sets boot, keeps source fields
      cyc(0, 1, 1, 0, '0, 0, 0, '0, 1);
      rd_reg(1);
      chk("R4", bus_rdata, 32'h301, "warm policy 1 readback");
      // R5: cold and warm together
      dtag = "R5";
      cyc(1, 1, 0, 0, '0, 0, 0, '0, 1);
      rd_reg(1);
      chk("R5", bus_rdata, 32'h1, "cold wins");
      // R6: non-privileged write and read
      dtag = "R6";
      wr_reg(32'h0000_0300, 0);
      chk("R6", {31'b0, bus_err}, 32'h1, "err pulse");
      rd_reg(0);
      chk("R6", bus_rdata, 32'h0, "nonpriv read data");
      idle(0);
      chk("R6", {31'b0, bus_err}, 32'h0, "err one cycle");
      rd_reg(1);
      chk("R6", bus_rdata, 32'h1, "unchanged");
      // R7: fuse drives select when enable clear, ignored when set
      dtag = "R7";
      idle(1); idle(1);
      chk("R7", {31'b0, boot_clk_sel}, 32'h1, "fuse=1 used");
      wr_reg(32'h0000_0100, 1);
      idle(1); idle(1);
      chk("R7", {31'b0, boot_clk_sel}, 32'h0, "sw choice 0 over fuse");
      // R10: other address and access during reset
      dtag = "R10";
      cyc(0, 0, 0, 1, 12'h004, 1, 0, 32'h0000_0301, 1);
      cyc(0, 0, 0, 1, 12'h004, 0, 1, '0, 0);
      cyc(0, 0, 0, 1, '0, 1, 0, 32'h0000_0200, 0);
      rd_reg(1);
      chk("R10", bus_rdata, 32'h100, "miss ignored");
      // random phase
      dtag = "";
      for (int i = 0; i < 4000; i++) begin
         logic c, w;
         logic [ADDR_W-1:0] a;
         c = ($urandom_range(0, 99) < 2);
         w = ($urandom_range(0, 99) < 4);
         a = ($urandom_range(0, 7) == 0) ? ADDR_W'($urandom_range(1, 15)) : '0;
         cyc(c, w, 1'($urandom), 1'($urandom), a, 1'($urandom), 1'($urandom),
             $urandom, ($urandom_range(0, 9) != 0));
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule